// File: doc/BRIEF.md
# Signed Q8.8 to binary16 converter

This block turns a signed fixed-point number with eight integer bits and eight fractional bits into a 16-bit IEEE half-precision value. The operand comes in as two bytes: the upper byte holds the integer part with its sign, the lower byte the fraction. The result goes out as two bytes: the upper byte carries bits 15..8 of the half-precision word, the lower byte bits 7..0.

A conversion is requested by raising `in_vld` with both bytes present. One clock later the packed result appears on the output bytes together with `out_vld`. When no request is present the output register keeps its last value. The datapath works on the magnitude of the operand. It locates the leading one to form the exponent, then normalises and rounds the bits below the leading one into the 10-bit fraction. Every input in the Q8.8 range maps to a normal, finite half-precision number or to zero, so the block never produces infinities, NaNs or subnormals.

Top module: `q88_to_half`

## Requirements
- R1: The result word is laid out as sign in bit 15, exponent in bits 14..10 biased by 15, and fraction in bits 9..0. `out_hi` carries word bits 15..8 and `out_lo` carries bits 7..0. On the input side, `in_hi` is bits 15..8 of the Q8.8 operand and `in_lo` is bits 7..0 (for example 0x01,0x00 = 1.0 gives 0x3C,0x00).
- R2: An all-zero operand yields 0x0000 (+0.0).
- R3: Bit 15 of the result equals bit 15 of the operand. The magnitude of a negative operand is its two's complement negation (0xFF00 = -1.0 gives 0xBC00).
- R4: The most negative operand 0x8000 converts exactly to -128.0, which is 0xD800.
- R5: For a nonzero operand whose magnitude has its leading one at bit position p (0..15), the exponent field is 15 + p - 8, unless the rounding carry of R8 applies. The smallest magnitude, 0x0001, gives 0x1C00.
- R6: When the magnitude has at most 11 significant bits, the result is the exact value of the operand.
- R7: Magnitude bits below the 10 kept fraction bits are rounded to nearest, with ties going to an even fraction. 0x0801 gives 0x4800 and 0x0803 gives 0x4802.
- R8: A rounding carry out of the fraction clears the fraction and raises the exponent by one. 0x7FFF gives 0x5800 (128.0).
- R9: The result and `out_vld` appear on the clock edge after the edge that samples `in_vld` high. While `in_vld` is low, `out_vld` is low and the output bytes hold their value.
- R10: While reset is asserted, `out_vld`, `out_hi` and `out_lo` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_vld | input | 1 | Operand present, conversion requested |
| in_hi | input | INT_BITS (8) | Operand upper byte: sign and integer part |
| in_lo | input | FRAC_BITS (8) | Operand lower byte: fractional part |
| out_vld | output | 1 | Result valid, one cycle after the request |
| out_hi | output | 8 | Result bits 15..8: sign, exponent, top two fraction bits |
| out_lo | output | 8 | Result bits 7..0: low fraction bits |

## Verification
The embedded properties watch the handshake timing and the hold of the output register on every cycle. They also check that the sign follows the operand, that zero maps to zero, and that the exponent of any nonzero result stays inside the range the Q8.8 format allows. The exact fraction, the rounding of ties, the exponent bump on a rounding carry and the -128.0 corner can only be shown by the bench. It applies all 65536 operands back to back and compares each result against a conversion that goes through the simulator's real arithmetic. Directed operands then pin down the corner values named in the requirements, along with the hold behaviour and the reset values.

// File: rtl/q2h_pkg.sv
package q2h_pkg;
  localparam int HALF_EXP_W = 5;
  localparam int HALF_MAN_W = 10;
  localparam int HALF_BIAS  = (1 << (HALF_EXP_W - 1)) - 1;

  typedef struct packed {
    logic                  sgn;
    logic [HALF_EXP_W-1:0] expo;
    logic [HALF_MAN_W-1:0] man;
  } half_t;
endpackage

// File: rtl/q2h_magnitude.sv
module q2h_magnitude #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  output logic         neg,
  output logic [W-1:0] mag
);
  always_comb begin
    neg = val[W-1];
    mag = neg ? (~val + W'(1)) : val;
  end
endmodule

// File: rtl/q2h_lead_one.sv
module q2h_lead_one #(
  parameter int W  = 16,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  mag,
  output logic [PW-1:0] pos,
  output logic          nz
);
  // above[i] is set when some bit above position i is one
  logic [W-1:0] above;
  logic [W-1:0] hit;

  assign above[W-1] = 1'b0;
  genvar g;
  generate
    for (g = W - 2; g >= 0; g--) begin : g_chain
      assign above[g] = above[g+1] | mag[g+1];
    end
    for (g = 0; g < W; g++) begin : g_hit
      assign hit[g] = mag[g] & ~above[g];
    end
  endgenerate

  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (hit[i]) pos = PW'(i);
    end
    nz = |mag;
  end
endmodule

// File: rtl/q2h_round_pack.sv
module q2h_round_pack
  import q2h_pkg::*;
#(
  parameter int W         = 16,
  parameter int FRAC_BITS = 8,
  localparam int PW       = $clog2(W),
  localparam int GRD      = W - 2 - HALF_MAN_W
) (
  input  logic          neg,
  input  logic [W-1:0]  mag,
  input  logic [PW-1:0] pos,
  input  logic          nz,
  output half_t         res
);
  logic [W-1:0]          norm;
  logic [HALF_MAN_W-1:0] kept;
  logic                  guard;
  logic                  sticky;
  logic                  up;
  logic [HALF_MAN_W:0]   sum;
  int                    e_i;

  always_comb begin
    norm   = mag << (PW'(W - 1) - pos);
    kept   = norm[W-2 -: HALF_MAN_W];
    guard  = norm[GRD];
    sticky = |norm[GRD-1:0];
    up     = guard & (sticky | kept[0]);
    sum    = {1'b0, kept} + (HALF_MAN_W+1)'(up);
    e_i    = int'(pos) + HALF_BIAS - FRAC_BITS + int'(sum[HALF_MAN_W]);
    if (nz) begin
      res.sgn  = neg;
      res.expo = e_i[HALF_EXP_W-1:0];
      res.man  = sum[HALF_MAN_W-1:0];
    end else begin
      res = '0;
    end
  end
endmodule

// File: rtl/q88_to_half.sv
module q88_to_half
  import q2h_pkg::*;
#(
  parameter int INT_BITS  = 8,
  parameter int FRAC_BITS = 8,
  localparam int W        = INT_BITS + FRAC_BITS,
  localparam int PW       = $clog2(W),
  localparam int OUT_W    = 1 + HALF_EXP_W + HALF_MAN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [INT_BITS-1:0]  in_hi,
  input  logic [FRAC_BITS-1:0] in_lo,
  output logic                 out_vld,
  output logic [7:0]           out_hi,
  output logic [7:0]           out_lo
);
  // reset: asserted at once, released on the clock
  logic [1:0] rst_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  logic [W-1:0]  operand;
  logic          neg;
  logic [W-1:0]  mag;
  logic [PW-1:0] pos;
  logic          nz;
  half_t         packed_res;

  assign operand = {in_hi, in_lo};

  q2h_magnitude #(.W(W)) u_mag (
    .val(operand), .neg(neg), .mag(mag)
  );

  q2h_lead_one #(.W(W)) u_lod (
    .mag(mag), .pos(pos), .nz(nz)
  );

  q2h_round_pack #(.W(W), .FRAC_BITS(FRAC_BITS)) u_rnd (
    .neg(neg), .mag(mag), .pos(pos), .nz(nz), .res(packed_res)
  );

  // next state
  logic [OUT_W-1:0] res_q, res_d;
  logic             vld_q, vld_d;
  always_comb begin
    vld_d = in_vld;
    res_d = in_vld ? packed_res : res_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_vld = vld_q;
  assign out_hi  = res_q[15:8];
  assign out_lo  = res_q[7:0];

  // R9
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_vld |=> out_vld);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_vld |=> (!out_vld && $stable({out_hi, out_lo})));
  // R2
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_vld && operand == '0) |=> ({out_hi, out_lo} == 16'h0000));
  // R3
  sign_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_vld |=> (out_hi[7] == $past(in_hi[INT_BITS-1])));
  // R5
  exp_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_vld && operand != '0) |=>
      ((int'(out_hi[6:2]) >= HALF_BIAS - FRAC_BITS) &&
       (int'(out_hi[6:2]) <= HALF_BIAS + INT_BITS - 1)));
endmodule

// File: tb/sim_q88_to_half.sv
module sim_q88_to_half;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_vld;
  logic [7:0] in_hi, in_lo;
  logic       out_vld;
  logic [7:0] out_hi, out_lo;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  q88_to_half u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .in_hi(in_hi), .in_lo(in_lo),
    .out_vld(out_vld), .out_hi(out_hi), .out_lo(out_lo)
  );

  // reference: convert through a double and round it to half precision
  function automatic logic [15:0] ref_half(input logic [15:0] x);
    real         r;
    logic [63:0] b;
    int          e;
    logic [9:0]  keep;
    logic [10:0] s;
    logic        g, st, sg;
    if (x == 16'h0000) return 16'h0000;
    r  = $itor($signed(x)) / 256.0;
    sg = (r < 0.0);
    if (sg) r = -r;
    b    = $realtobits(r);
    e    = int'(b[62:52]) - 1023 + 15;
    keep = b[51:42];
    g    = b[41];
    st   = |b[40:0];
    s    = {1'b0, keep} + 11'((g & (st | keep[0])) ? 1 : 0);
    if (s[10]) e = e + 1;
    return {sg, 5'(e), s[9:0]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_for(input logic [15:0] x);
    logic [15:0] m;
    int          p;
    if (x == 16'h0000) return "R2";
    if (x == 16'h8000) return "R4";
    m = x[15] ? (~x + 16'd1) : x;
    p = 0;
    for (int i = 0; i < 16; i++) if (m[i]) p = i;
    if (p > 10 && (m & ((16'd1 << (p - 10)) - 16'd1)) != 0) return "R7";
    return "R6";
  endfunction

  task automatic directed(input string req, input logic [15:0] x, input logic [15:0] exp);
    @(negedge clk);
    in_vld = 1'b1; {in_hi, in_lo} = x;
    @(negedge clk);
    in_vld = 1'b0;
    check(req, {out_hi, out_lo}, exp);
    check({req, " valid"}, {15'd0, out_vld}, 16'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected under 190000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [15:0] prev;
    logic [15:0] held;
    rst_n = 1'b0; in_vld = 1'b0; in_hi = 8'h12; in_lo = 8'h34;
    repeat (3) @(negedge clk);
    // R10: reset values
    check("R10", {out_hi, out_lo}, 16'h0000);
    check("R10 valid", {15'd0, out_vld}, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // exhaustive sweep, one operand per cycle
    prev = 16'h0000;
    for (int k = 0; k <= 65536; k++) begin
      if (k > 0) begin
        check(tag_for(prev), {out_hi, out_lo}, ref_half(prev));
      end
      if (k < 65536) begin
        prev   = 16'(k);
        in_vld = 1'b1;
        {in_hi, in_lo} = prev;
      end else begin
        in_vld = 1'b0;
      end
      @(negedge clk);
    end

    // R9: idle cycles hold the last result, valid low
    held = {out_hi, out_lo};
    check("R9 last", held, 16'h9C00);
    in_hi = 8'h55; in_lo = 8'hAA;
    repeat (3) @(negedge clk);
    check("R9 hold", {out_hi, out_lo}, held);
    check("R9 idle", {15'd0, out_vld}, 16'd0);

    directed("R1", 16'h0100, 16'h3C00);
    directed("R2", 16'h0000, 16'h0000);
    directed("R3", 16'hFF00, 16'hBC00);
    directed("R4", 16'h8000, 16'hD800);
    directed("R5", 16'h0001, 16'h1C00);
    directed("R6", 16'h7F80, 16'h57F8);
    directed("R7 tie down", 16'h0801, 16'h4800);
    directed("R7 tie up", 16'h0803, 16'h4802);
    directed("R8", 16'h7FFF, 16'h5800);
    finish_run();
  end
endmodule